// File: doc/BRIEF.md
# SPI Command Frame Front End

This block is the serial front end of a sixteen-channel low-side output controller. An external host sends 16-bit frames. Each frame holds a control byte in its upper half and a data byte in its lower half. The block decodes the control byte when chip select is released. Some commands carry output data; for those it issues a one-cycle commit strobe with the bank select, the combine mode (OR or AND with the parallel inputs) and the data byte. The output latches and the diagnosis storage sit outside the block and connect through plain ports.

Every frame returns a response word on SO. The command of the previous frame chooses that word:
- a bank's two-bit-per-channel diagnosis word;
- a readback word with the eight parallel input levels and one fault bit per channel;
- an echo of SI for one whole frame;
- all zeros, after an echo frame, an unknown command or a malformed frame.

SCLK, SI and CS are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are detected in the system domain. The system clock must run at least eight times faster than SCLK.

The frame state machine has three states:
- `ST_IDLE`: chip select is high.
- `ST_SHIFT`: a normal frame is in progress.
- `ST_ECHO`: a loopback frame is in progress.

It has four transitions:
- `ST_IDLE`→`ST_SHIFT` on a detected CS fall when no echo is armed.
- `ST_IDLE`→`ST_ECHO` on a detected CS fall when the previous frame armed echo.
- `ST_SHIFT`→`ST_IDLE` on a detected CS rise. The frame is decoded and committed here.
- `ST_ECHO`→`ST_IDLE` on a detected CS rise. The frame is discarded here.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After reset, `so_oe` and `cmd_stb` are low and the response of the first frame is all zeros.
- R2: While CS is high, `so_oe` stays low and activity on SCLK and SI causes no commit and does not alter the response of the next frame.
- R3: Frames are shifted most significant bit first. SI is taken on each falling SCLK edge. The response MSB is driven from the CS fall, and each later bit appears after a rising SCLK edge.
- R4: A control byte with upper nibble 0011 (OR) or 1111 (AND) and a valid bank nibble commits on the CS rise. The commit is a single-cycle `cmd_stb` with `cmd_and` = 1 for AND, 0 for OR, and `cmd_data` = the received data byte.
- R5: The lower nibble of the control byte selects the bank. 0000 selects channels 1–8 (`cmd_bank` = 0) and 1111 selects channels 9–16 (`cmd_bank` = 1). Any other lower nibble makes the control word invalid.
- R6: Upper nibble 0000 (diagnose only) and upper nibble 1100 (readback) commit nothing. The data byte has no effect.
- R7: After a diagnose-only, OR or AND command, the next response is the full diagnosis word of the selected bank: `diag_lo` for bank 0, `diag_hi` for bank 1.
- R8: After a readback command, the next response is `{par_in, f}`. Here `par_in` is ordered IN12, IN11, IN10, IN9, IN4, IN3, IN2, IN1 from its MSB. `f` is `fault_ok[7:0]` for bank 0 or `fault_ok[15:8]` for bank 1, with the highest channel at the MSB and 1 meaning no fault.
- R9: After an echo command (upper nibble 1010), during the next frame SO follows SI. Nothing received in that frame is committed, and the response of the frame after it is all zeros.
- R10: A control word outside the ten valid ones commits nothing, and the next response is all zeros.
- R11: A frame with a bit count other than 16 at the CS rise is discarded. Nothing is committed and the next response is all zeros.
- R12: `so_oe` rises only after a detected CS fall and is low again by the cycle in which a commit strobe appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, low at CS transitions |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, MSB first |
| so | output | 1 | Serial response data |
| so_oe | output | 1 | Output enable for SO (high impedance when low) |
| par_in | input | 8 | Parallel input levels, IN12..IN9, IN4..IN1 from MSB |
| diag_lo | input | 16 | Full diagnosis word for channels 1–8 |
| diag_hi | input | 16 | Full diagnosis word for channels 9–16 |
| fault_ok | input | 16 | One bit per channel, bit i = channel i+1, 1 = no fault |
| cmd_stb | output | 1 | One-cycle commit strobe for OR/AND commands |
| cmd_bank | output | 1 | Committed bank: 0 = channels 1–8, 1 = channels 9–16 |
| cmd_and | output | 1 | Committed combine mode: 1 = AND, 0 = OR |
| cmd_data | output | 8 | Committed data byte |

## Verification
Each pin passes two synchronizer flops and one edge register. The block therefore reacts on the third system clock edge after a pin change: `so_oe` rises, SO takes its next bit, or the commit strobe and its fields appear three edges after CS, SCLK or CS respectively move. In an echo frame, SO follows SI two edges after SI moves. The bench's reference model is fed from a four-deep history of pin samples, so it uses exactly those delays. Its predictions are compared on every falling clock edge, half a period after the update. The host task samples SO just before each falling SCLK edge, eight system clocks after the rising edge that moved it, and each captured response word is compared with the value the requirements give.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int CTRL_W  = 8;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = CTRL_W + DATA_W;
    localparam int NIB_W   = CTRL_W / 2;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    // operation nibble (upper half of the control byte)
    localparam logic [NIB_W-1:0] OP_DIAG = 4'b0000;
    localparam logic [NIB_W-1:0] OP_RDBK = 4'b1100;
    localparam logic [NIB_W-1:0] OP_ECHO = 4'b1010;
    localparam logic [NIB_W-1:0] OP_OR   = 4'b0011;
    localparam logic [NIB_W-1:0] OP_AND  = 4'b1111;

    // bank nibble (lower half of the control byte)
    localparam logic [NIB_W-1:0] BANK_LO = '0;
    localparam logic [NIB_W-1:0] BANK_HI = '1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ECHO  = 2'd2
    } frame_st_t;

    typedef enum logic [2:0] {
        CK_BAD  = 3'd0,
        CK_DIAG = 3'd1,
        CK_RDBK = 3'd2,
        CK_ECHO = 3'd3,
        CK_OR   = 3'd4,
        CK_AND  = 3'd5
    } cmd_kind_t;

    typedef enum logic [1:0] {
        RK_ZERO = 2'd0,
        RK_DIAG = 2'd1,
        RK_RDBK = 2'd2
    } resp_kind_t;

endpackage

// File: rtl/spi_sync_chain.sv
module spi_sync_chain #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_cmd_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output cmd_kind_t         kind,
    output logic              bank
);

    logic [NIB_W-1:0] op_nib;
    logic [NIB_W-1:0] bank_nib;
    logic             bank_ok;

    assign op_nib   = ctrl[CTRL_W-1:NIB_W];
    assign bank_nib = ctrl[NIB_W-1:0];
    assign bank_ok  = (bank_nib == BANK_LO) || (bank_nib == BANK_HI);
    assign bank     = (bank_nib == BANK_HI);

    always_comb begin
        kind = CK_BAD;
        if (bank_ok) begin
            unique case (op_nib)
                OP_DIAG: kind = CK_DIAG;
                OP_RDBK: kind = CK_RDBK;
                OP_ECHO: kind = CK_ECHO;
                OP_OR:   kind = CK_OR;
                OP_AND:  kind = CK_AND;
                default: kind = CK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/spi_resp_mux.sv
module spi_resp_mux
    import spi_cmd_pkg::*;
(
    input  resp_kind_t         kind,
    input  logic               bank,
    input  logic [FRAME_W-1:0] diag_lo,
    input  logic [FRAME_W-1:0] diag_hi,
    input  logic [DATA_W-1:0]  par_in,
    input  logic [FRAME_W-1:0] fault_ok,
    output logic [FRAME_W-1:0] word
);

    logic [DATA_W-1:0] fault_byte;

    assign fault_byte = bank ? fault_ok[FRAME_W-1:DATA_W] : fault_ok[DATA_W-1:0];

    always_comb begin
        unique case (kind)
            RK_DIAG: word = bank ? diag_hi : diag_lo;
            RK_RDBK: word = {par_in, fault_byte};
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               si,
    output logic               so,
    output logic               so_oe,
    input  logic [DATA_W-1:0]  par_in,
    input  logic [FRAME_W-1:0] diag_lo,
    input  logic [FRAME_W-1:0] diag_hi,
    input  logic [FRAME_W-1:0] fault_ok,
    output logic               cmd_stb,
    output logic               cmd_bank,
    output logic               cmd_and,
    output logic [DATA_W-1:0]  cmd_data
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    // pin synchronization: {cs_n, sclk, si}
    logic [2:0] pin_s;
    logic       cs_s, sclk_s, si_s;
    logic       cs_prev, sclk_prev;
    logic       cs_fall, cs_rise, sclk_rise, sclk_fall;

    spi_sync_chain #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, sclk, si}),
        .q    (pin_s)
    );

    assign cs_s   = pin_s[2];
    assign sclk_s = pin_s[1];
    assign si_s   = pin_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_s;
            sclk_prev <= sclk_s;
        end
    end

    assign cs_fall   =  cs_prev   & ~cs_s;
    assign cs_rise   = ~cs_prev   &  cs_s;
    assign sclk_rise = ~sclk_prev &  sclk_s;
    assign sclk_fall =  sclk_prev & ~sclk_s;

    // frame state
    frame_st_t        state_q, state_d;
    logic [FRAME_W-1:0] sh_q;
    logic             so_q;
    logic [CNT_W-1:0] cnt_q;
    resp_kind_t       rk_q;
    logic             rbank_q;
    logic             echo_arm_q;

    // decode of the received control byte
    cmd_kind_t dec_kind;
    logic      dec_bank;

    spi_cmd_decode u_dec (
        .ctrl(sh_q[FRAME_W-1:DATA_W]),
        .kind(dec_kind),
        .bank(dec_bank)
    );

    // response word chosen by the previous command
    logic [FRAME_W-1:0] resp_word;

    spi_resp_mux u_resp (
        .kind    (rk_q),
        .bank    (rbank_q),
        .diag_lo (diag_lo),
        .diag_hi (diag_hi),
        .par_in  (par_in),
        .fault_ok(fault_ok),
        .word    (resp_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) state_d = echo_arm_q ? ST_ECHO : ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_rise) state_d = ST_IDLE;
            end
            ST_ECHO: begin
                if (cs_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            so_q       <= 1'b0;
            cnt_q      <= '0;
            rk_q       <= RK_ZERO;
            rbank_q    <= 1'b0;
            echo_arm_q <= 1'b0;
            cmd_stb    <= 1'b0;
            cmd_bank   <= 1'b0;
            cmd_and    <= 1'b0;
            cmd_data   <= '0;
        end else begin
            cmd_stb <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall) begin
                        sh_q       <= resp_word;
                        so_q       <= resp_word[FRAME_W-1];
                        cnt_q      <= '0;
                        echo_arm_q <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (cs_rise) begin
                        rk_q <= RK_ZERO;
                        if (cnt_q == CNT_FULL) begin
                            unique case (dec_kind)
                                CK_DIAG: begin
                                    rk_q    <= RK_DIAG;
                                    rbank_q <= dec_bank;
                                end
                                CK_RDBK: begin
                                    rk_q    <= RK_RDBK;
                                    rbank_q <= dec_bank;
                                end
                                CK_ECHO: begin
                                    echo_arm_q <= 1'b1;
                                end
                                CK_OR, CK_AND: begin
                                    rk_q     <= RK_DIAG;
                                    rbank_q  <= dec_bank;
                                    cmd_stb  <= 1'b1;
                                    cmd_bank <= dec_bank;
                                    cmd_and  <= (dec_kind == CK_AND);
                                    cmd_data <= sh_q[DATA_W-1:0];
                                end
                                default: rk_q <= RK_ZERO;
                            endcase
                        end
                    end else begin
                        if (sclk_fall) begin
                            sh_q <= {sh_q[FRAME_W-2:0], si_s};
                            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
                        end
                        if (sclk_rise) so_q <= sh_q[FRAME_W-1];
                    end
                end
                ST_ECHO: begin
                    if (cs_rise) rk_q <= RK_ZERO;
                end
                default: rk_q <= RK_ZERO;
            endcase
        end
    end

    assign so    = (state_q == ST_ECHO) ? si_s : so_q;
    assign so_oe = (state_q != ST_IDLE);

endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk
    import spi_cmd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      so,
    input logic      so_oe,
    input logic      cmd_stb,
    input logic      cs_fall,
    input logic      cs_rise,
    input logic      sclk_rise,
    input frame_st_t st
);

    assert_oe_after_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(cs_fall));

    assert_oe_low_at_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> !so_oe);

    assert_commit_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(cs_rise));

    assert_commit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    assert_no_commit_from_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> ($past(st) == ST_SHIFT));

    assert_so_moves_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && $past(st) == ST_SHIFT && !$past(sclk_rise)) |-> $stable(so));

endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .so       (so),
    .so_oe    (so_oe),
    .cmd_stb  (cmd_stb),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .sclk_rise(sclk_rise),
    .st       (state_q)
);

// File: tb/tb_spi_cmd_frontend.sv
module tb_spi_cmd_frontend;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 8;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        so, so_oe;
    logic [7:0]  par_in = 8'h6B;
    logic [15:0] diag_lo = 16'hA5C3;
    logic [15:0] diag_hi = 16'h1E2D;
    logic [15:0] fault_ok = 16'hB74E;
    logic        cmd_stb, cmd_bank, cmd_and;
    logic [7:0]  cmd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_frontend dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .par_in(par_in), .diag_lo(diag_lo),
        .diag_hi(diag_hi), .fault_ok(fault_ok), .cmd_stb(cmd_stb),
        .cmd_bank(cmd_bank), .cmd_and(cmd_and), .cmd_data(cmd_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit          h_cs [4];
    bit          h_sck[4];
    bit          h_si [4];
    bit          m_in, m_echo, m_arm, m_bank, m_so;
    int          m_rk;      // 0 zero, 1 diagnosis, 2 readback
    int          m_bits;
    logic [15:0] m_word;
    bit          e_stb, e_bank, e_and;
    logic [7:0]  e_data;

    function automatic logic [15:0] model_resp(input int rk, input bit bank);
        if (rk == 1) return bank ? diag_hi : diag_lo;
        if (rk == 2) return {par_in, bank ? fault_ok[15:8] : fault_ok[7:0]};
        return 16'h0000;
    endfunction

    initial begin
        for (int i = 0; i < 4; i++) begin
            h_cs[i] = 1'b1; h_sck[i] = 1'b0; h_si[i] = 1'b0;
        end
        m_in = 0; m_echo = 0; m_arm = 0; m_bank = 0; m_so = 0;
        m_rk = 0; m_bits = 0; m_word = '0;
        e_stb = 0; e_bank = 0; e_and = 0; e_data = '0;
    end

    always @(posedge clk) begin
        for (int i = 3; i > 0; i--) begin
            h_cs[i] = h_cs[i-1]; h_sck[i] = h_sck[i-1]; h_si[i] = h_si[i-1];
        end
        h_cs[0] = cs_n; h_sck[0] = sclk; h_si[0] = si;
        e_stb = 1'b0;
        if (!rst_n) begin
            m_in = 0; m_echo = 0; m_arm = 0; m_bank = 0; m_so = 0;
            m_rk = 0; m_bits = 0; m_word = '0;
            e_bank = 0; e_and = 0; e_data = '0;
        end else if (!m_in && h_cs[3] && !h_cs[2]) begin
            m_in = 1; m_echo = m_arm; m_arm = 0;
            m_word = model_resp(m_rk, m_bank);
            m_so = m_word[15]; m_bits = 0;
        end else if (m_in && !h_cs[3] && h_cs[2]) begin
            m_in = 0;
            if (m_echo) begin
                m_echo = 0; m_rk = 0;
            end else begin
                logic [3:0] op, bk;
                op = m_word[15:12]; bk = m_word[11:8];
                m_rk = 0;
                if (m_bits == 16 && (bk == 4'h0 || bk == 4'hF)) begin
                    case (op)
                        4'b0000: begin m_rk = 1; m_bank = bk[0]; end
                        4'b1100: begin m_rk = 2; m_bank = bk[0]; end
                        4'b1010: m_arm = 1;
                        4'b0011, 4'b1111: begin
                            m_rk = 1; m_bank = bk[0];
                            e_stb = 1; e_bank = bk[0];
                            e_and = (op == 4'b1111); e_data = m_word[7:0];
                        end
                        default: m_rk = 0;
                    endcase
                end
            end
        end else if (m_in && !m_echo) begin
            if (h_sck[3] && !h_sck[2]) begin
                m_word = {m_word[14:0], h_si[2]};
                m_bits++;
            end
            if (!h_sck[3] && h_sck[2]) m_so = m_word[15];
        end
    end

    // per-clock comparison, half a period after the update
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(so_oe === m_in, "R12 so_oe", {31'd0, so_oe}, {31'd0, m_in});
            if (m_in) begin
                if (m_echo)
                    check(so === h_si[1], "R9 echo so", {31'd0, so}, {31'd0, h_si[1]});
                else
                    check(so === m_so, "R3 so bit", {31'd0, so}, {31'd0, m_so});
            end
            check(cmd_stb === e_stb, "R4 cmd_stb", {31'd0, cmd_stb}, {31'd0, e_stb});
            if (e_stb)
                check({cmd_bank, cmd_and, cmd_data} === {e_bank, e_and, e_data},
                      "R5 commit fields", {22'd0, cmd_bank, cmd_and, cmd_data},
                      {22'd0, e_bank, e_and, e_data});
            if (cmd_stb) stb_cnt++;
        end
    end

    // ---------------- host tasks ----------------
    task automatic xfer(input logic [31:0] w, input int nb, output logic [31:0] cap);
        cap = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF_SCK) @(negedge clk);
        for (int i = nb - 1; i >= 0; i--) begin
            si = w[i];
            sclk = 1'b1;
            repeat (HALF_SCK) @(negedge clk);
            cap = {cap[30:0], so};
            sclk = 1'b0;
            repeat (HALF_SCK) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (2 * HALF_SCK) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w, input logic [15:0] exp, input string req);
        logic [31:0] cap;
        xfer({16'd0, w}, 16, cap);
        check(cap[15:0] === exp, req, cap, {16'd0, exp});
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int s0;
        logic [31:0] cap;
        repeat (5) @(negedge clk);
        check(so_oe === 1'b0, "R1 so_oe in reset", {31'd0, so_oe}, 32'd0);
        check(cmd_stb === 1'b0, "R1 cmd_stb in reset", {31'd0, cmd_stb}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1/R4: OR bank low, first response is zero
        frame(16'h3091, 16'h0000, "R1 first response");
        check(stb_cnt == 1, "R4 OR commit count", stb_cnt, 1);
        check({cmd_bank, cmd_and, cmd_data} === {1'b0, 1'b0, 8'h91}, "R4 OR fields",
              {22'd0, cmd_bank, cmd_and, cmd_data}, {22'd0, 2'b00, 8'h91});

        // R5/R7: AND bank high; response is bank-low diagnosis from the OR command
        frame(16'hF0A5 | 16'h0F00, diag_lo, "R7 diag after OR lo");
        check({cmd_bank, cmd_and, cmd_data} === {1'b1, 1'b1, 8'hA5}, "R5 AND bank hi fields",
              {22'd0, cmd_bank, cmd_and, cmd_data}, {22'd0, 2'b11, 8'hA5});

        // R6: diagnose-only low with data FF, no commit
        s0 = stb_cnt;
        frame(16'h00FF, diag_hi, "R7 diag after AND hi");
        check(stb_cnt == s0, "R6 diag-only no commit", stb_cnt, s0);

        // readback high; response from diagnose-only low
        frame(16'hCF00, diag_lo, "R6 diag-only response lo");
        check(stb_cnt == s0, "R6 readback no commit", stb_cnt, s0);

        // R8: readback high response
        frame(16'h0F00, {8'h6B, 8'hB7}, "R8 readback hi");
        frame(16'hC000, diag_hi, "R6 diag-only response hi");
        frame(16'hA000, {8'h6B, 8'h4E}, "R8 readback lo");

        // R9: echo frame, then zero
        s0 = stb_cnt;
        frame(16'h3055, 16'h3055, "R9 echo loopback");
        check(stb_cnt == s0, "R9 echo frame no commit", stb_cnt, s0);
        frame(16'h0000, 16'h0000, "R9 zero after echo");

        // R10: unknown op nibble and bad bank nibble
        frame(16'h7000, diag_lo, "R7 diag lo before bad word");
        check(stb_cnt == s0, "R10 unknown op no commit", stb_cnt, s0);
        frame(16'h3500, 16'h0000, "R10 zero after unknown op");
        check(stb_cnt == s0, "R10 bad bank no commit", stb_cnt, s0);
        frame(16'h0000, 16'h0000, "R10 zero after bad bank");

        // R11: short and long frames are discarded
        xfer(32'h0000_030F, 12, cap);
        check(stb_cnt == s0, "R11 short frame no commit", stb_cnt, s0);
        frame(16'h0F00, 16'h0000, "R11 zero after short frame");
        xfer(32'h0003_0F77, 20, cap);
        check(stb_cnt == s0, "R11 long frame no commit", stb_cnt, s0);
        frame(16'h0F00, 16'h0000, "R11 zero after long frame");

        // R2: activity with CS high is ignored
        for (int i = 0; i < 12; i++) begin
            si = i[0];
            sclk = ~sclk;
            repeat (HALF_SCK) @(negedge clk);
            check(so_oe === 1'b0, "R2 so_oe with CS high", {31'd0, so_oe}, 32'd0);
        end
        sclk = 1'b0;
        repeat (2 * HALF_SCK) @(negedge clk);
        check(stb_cnt == s0, "R2 no commit with CS high", stb_cnt, s0);
        frame(16'h0000, diag_hi, "R2 response kept across idle activity");

        // R3: asymmetric pattern checks bit order of response
        diag_lo = 16'h8001;
        frame(16'h0000, 16'h8001, "R3 MSB-first response");

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule